// File: doc/BRIEF.md
# DDR SDRAM Physical-Layer Datapath

This block is the last stage between a DDR SDRAM command controller and the pads of a 16-bit memory device. The controller hands it a command, bank, address, write enable, write word and read enable one cycle early (the "next" values). The block registers them, drives the command pins, and regenerates the differential memory clock from quarter-phase copies of the base clock. It splits each 32-bit write word into two 16-bit double-data-rate beats, centred on a pair of byte strobes, and it turns read beats captured on a feedback-derived clock back into 32-bit words.

The write enable and the first write word are presented in the same cycle as the write command. The read enable is presented in the same cycle as the read command. Each enable is held for half the burst length in base-clock cycles. The block adds every delay needed to reach the data pins and to recover the read words. The pads themselves are outside the block. The data and strobe buses therefore leave as separate output, output-enable and input signals.

Read words come out as a valid-only stream in the feedback domain, one word per cycle while valid is high. This stream has no ready input and accepts no back-pressure. The consumer, usually a clock-crossing buffer, must take every word. That buffer needs room for at least one burst (half the burst length in words) plus one word. All resets are active-high, synchronous to their own clock, and must be held for at least two cycles of that clock.

Top module: `ddr_phy`

## Requirements
- R1: The command outputs (clock enable, chip select, row strobe, column strobe, write strobe, bank, address) all take the values sampled on the previous rising edge of `clk`. While `rst` is asserted they hold the idle state: clock enable 0, the four active-low strobes 1, bank and address 0.
- R2: `mem_ck_p` rises on the rising edge of `clk_p90` and falls on the rising edge of `clk_p270`. `mem_ck_n` is always its complement. `mem_ck_p` stays low while its domain resets are asserted.
- R3: A write word sampled at `clk` edge k is driven on `mem_dq_o` during base cycle k+1. The j-th word of a burst is driven during cycle k+1+j. Bits 15:0 are driven while `clk` is high and bits 31:16 while `clk` is low.
- R4: `mem_dq_oe` is high exactly during base cycles that carry a write word and is low otherwise, including during reset.
- R5: Both bits of `mem_dqs_o` are always equal. During a write word's cycle the strobe is driven high while `clk_p90` is high and driven low in the following `clk_p90`-low half. One driven-low half-cycle precedes the first rising strobe of a burst, and `mem_dqs_oe` is low at all other times.
- R6: A read word is assembled from the `mem_dq_i` value sampled at a `rclk_p90` rising edge (bits 15:0) and the value sampled at the next `rclk_p270` rising edge (bits 31:16).
- R7: For a read enable sampled at `clk` edge k, `rd_valid` is high for the `rclk_p270` cycle that starts with the first such edge after base cycle k+CAS_LAT+1, with the word in `rd_data`. A held enable yields one valid word per cycle. `rd_valid` is low otherwise and during reset.
- R8: Write and read enables are held for BURST_LEN/2 base cycles per burst. Bursts may follow each other with no gap, and the data and strobe then run without interruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock for command and write paths |
| rst | input | 1 | Synchronous reset for `clk` |
| clk_p90 | input | 1 | Base clock delayed by a quarter period |
| rst_p90 | input | 1 | Synchronous reset for `clk_p90` |
| clk_p270 | input | 1 | Base clock delayed by three quarters of a period |
| rst_p270 | input | 1 | Synchronous reset for `clk_p270` |
| rclk_p90 | input | 1 | Feedback memory clock delayed by a quarter period |
| rst_r90 | input | 1 | Synchronous reset for `rclk_p90` |
| rclk_p270 | input | 1 | Feedback memory clock delayed by three quarters |
| rst_r270 | input | 1 | Synchronous reset for `rclk_p270` |
| nx_cke | input | 1 | Next clock enable |
| nx_cs_n | input | 1 | Next chip select, active low |
| nx_ras_n | input | 1 | Next row strobe, active low |
| nx_cas_n | input | 1 | Next column strobe, active low |
| nx_we_n | input | 1 | Next write strobe, active low |
| nx_ba | input | BA_W | Next bank |
| nx_addr | input | ADDR_W | Next address |
| nx_wr_en | input | 1 | Write enable, starts with the write command |
| nx_wr_data | input | DATA_W | Write word, first one with the write command |
| nx_rd_en | input | 1 | Read enable, starts with the read command |
| rd_data | output | DATA_W | Assembled read word (feedback domain) |
| rd_valid | output | 1 | Read word valid, no back-pressure |
| mem_ck_p | output | 1 | Memory clock, true |
| mem_ck_n | output | 1 | Memory clock, complement |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Memory chip select |
| mem_ras_n | output | 1 | Memory row strobe |
| mem_cas_n | output | 1 | Memory column strobe |
| mem_we_n | output | 1 | Memory write strobe |
| mem_ba | output | BA_W | Memory bank |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W/2 | Data beats toward the pad |
| mem_dq_oe | output | 1 | Data pad output enable |
| mem_dq_i | input | DATA_W/2 | Data from the pad |
| mem_dqs_o | output | DATA_W/16 | Byte strobes toward the pads |
| mem_dqs_oe | output | 1 | Strobe pad output enable |

## Verification
The bench uses the default build: 32-bit words, CAS latency 2 and burst length 4, so every burst is two words over two base cycles. This small setting lets one run cover a full 64-pattern sweep of the command strobes and bank bits. It also covers write and read bursts separated by gaps of zero, one and two cycles, so preamble, postamble and seamless continuation are all checked. Each base cycle is checked against expectations derived from the cycle in which each input was presented.

// File: rtl/ddr_phy_pkg.sv
package ddr_phy_pkg;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/ddr_cmd_reg.sv
module ddr_cmd_reg
  import ddr_phy_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              nx_ctl,
  input  logic [BA_W-1:0]   nx_ba,
  input  logic [ADDR_W-1:0] nx_addr,
  output ctl_t              q_ctl,
  output logic [BA_W-1:0]   q_ba,
  output logic [ADDR_W-1:0] q_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ctl  <= CTL_IDLE;
      q_ba   <= '0;
      q_addr <= '0;
    end else begin
      q_ctl  <= nx_ctl;
      q_ba   <= nx_ba;
      q_addr <= nx_addr;
    end
  end

  // R1
  cmd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({q_ctl, q_ba, q_addr} == $past({nx_ctl, nx_ba, nx_addr})));

endmodule

// File: rtl/ddr_ck_gen.sv
module ddr_ck_gen (
  input  logic clk_p90,
  input  logic rst_p90,
  input  logic clk_p270,
  input  logic rst_p270,
  output logic ck_p,
  output logic ck_n
);

  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk_p90) begin
    if (rst_p90) rise_q <= 1'b0;
    else         rise_q <= ~fall_q;
  end

  always_ff @(posedge clk_p270) begin
    if (rst_p270) fall_q <= 1'b0;
    else          fall_q <= rise_q;
  end

  assign ck_p = rise_q ^ fall_q;
  assign ck_n = ~ck_p;

  // R2
  ck_low_before_rise_chk: assert property (@(posedge clk_p90) disable iff (rst_p90 || rst_p270)
    ck_p == 1'b0);

endmodule

// File: rtl/ddr_wr_path.sv
module ddr_wr_path #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_p90,
  input  logic              rst_p90,
  input  logic              nx_wr_en,
  input  logic [DATA_W-1:0] nx_wr_data,
  output logic [DATA_W/2-1:0]  dq_o,
  output logic                 dq_oe,
  output logic [DATA_W/16-1:0] dqs_o,
  output logic                 dqs_oe
);

  localparam int DQ_W  = DATA_W / 2;
  localparam int DQS_W = DQ_W / 8;
  localparam int HALF  = BURST_LEN / 2;

  // Stage A: word sampled together with the write command.
  logic              a_en;
  logic [DATA_W-1:0] a_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_en   <= 1'b0;
      a_data <= '0;
    end else begin
      a_en   <= nx_wr_en;
      a_data <= nx_wr_data;
    end
  end

  // Stage B: two beats held for one base cycle, selected by clock level.
  logic            b_en;
  logic [DQ_W-1:0] b_lo;
  logic [DQ_W-1:0] b_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_en <= 1'b0;
      b_lo <= '0;
      b_hi <= '0;
    end else begin
      b_en <= a_en;
      b_lo <= a_data[DQ_W-1:0];
      b_hi <= a_data[DATA_W-1:DQ_W];
    end
  end

  always_comb begin
    dq_o  = clk ? b_lo : b_hi;
    dq_oe = b_en;
  end

  // Strobe domain: quarter-phase sampling of stage A.
  logic s_cur;
  logic s_prev;

  always_ff @(posedge clk_p90) begin
    if (rst_p90) begin
      s_cur  <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_cur  <= a_en;
      s_prev <= s_cur;
    end
  end

  logic strobe_lvl;
  always_comb begin
    strobe_lvl = clk_p90 & s_prev;
    dqs_oe     = clk_p90 ? s_prev : (s_prev | s_cur);
  end

  for (genvar g = 0; g < DQS_W; g++) begin : g_lane
    assign dqs_o[g] = strobe_lvl;
  end

  // Assertion support: length of each write-enable run.
  logic [7:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (nx_wr_en) run_q <= run_q + 8'd1;
    else               run_q <= '0;
  end

  // R8
  wr_run_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!nx_wr_en && run_q != 0) |-> ((int'(run_q) % HALF) == 0));

  // R4
  dq_oe_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (dq_oe == $past(nx_wr_en, 2)));

endmodule

// File: rtl/ddr_rd_path.sv
module ddr_rd_path #(
  parameter int DATA_W    = 32,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rclk_p90,
  input  logic              rst_r90,
  input  logic              rclk_p270,
  input  logic              rst_r270,
  input  logic              nx_rd_en,
  input  logic [DATA_W/2-1:0] dq_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int DQ_W = DATA_W / 2;
  localparam int HALF = BURST_LEN / 2;

  // Read-enable delay line in the base domain: tap CAS_LAT is the enable
  // sampled CAS_LAT edges earlier.
  logic [CAS_LAT:0] en_pipe;

  always_ff @(posedge clk) begin
    if (rst) en_pipe <= '0;
    else     en_pipe <= {en_pipe[CAS_LAT-1:0], nx_rd_en};
  end

  // First half: low beat and delayed enable.
  logic            lo_en;
  logic [DQ_W-1:0] lo_q;

  always_ff @(posedge rclk_p90) begin
    if (rst_r90) begin
      lo_en <= 1'b0;
      lo_q  <= '0;
    end else begin
      lo_en <= en_pipe[CAS_LAT];
      lo_q  <= dq_i;
    end
  end

  // Second half: high beat completes the word.
  always_ff @(posedge rclk_p270) begin
    if (rst_r270) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= lo_en;
      rd_data  <= {dq_i, lo_q};
    end
  end

  // Assertion support: length of each valid run.
  logic [7:0] vrun_q;
  always_ff @(posedge rclk_p270) begin
    if (rst_r270)      vrun_q <= '0;
    else if (rd_valid) vrun_q <= vrun_q + 8'd1;
    else               vrun_q <= '0;
  end

  // R7
  rd_run_len_chk: assert property (@(posedge rclk_p270) disable iff (rst_r270)
    (!rd_valid && vrun_q != 0) |-> ((int'(vrun_q) % HALF) == 0));

endmodule

// File: rtl/ddr_phy.sv
module ddr_phy
  import ddr_phy_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 13,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clk_p90,
  input  logic                  rst_p90,
  input  logic                  clk_p270,
  input  logic                  rst_p270,
  input  logic                  rclk_p90,
  input  logic                  rst_r90,
  input  logic                  rclk_p270,
  input  logic                  rst_r270,
  input  logic                  nx_cke,
  input  logic                  nx_cs_n,
  input  logic                  nx_ras_n,
  input  logic                  nx_cas_n,
  input  logic                  nx_we_n,
  input  logic [BA_W-1:0]       nx_ba,
  input  logic [ADDR_W-1:0]     nx_addr,
  input  logic                  nx_wr_en,
  input  logic [DATA_W-1:0]     nx_wr_data,
  input  logic                  nx_rd_en,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  mem_ck_p,
  output logic                  mem_ck_n,
  output logic                  mem_cke,
  output logic                  mem_cs_n,
  output logic                  mem_ras_n,
  output logic                  mem_cas_n,
  output logic                  mem_we_n,
  output logic [BA_W-1:0]       mem_ba,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/2-1:0]   mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W/2-1:0]   mem_dq_i,
  output logic [DATA_W/16-1:0]  mem_dqs_o,
  output logic                  mem_dqs_oe
);

  ctl_t nx_ctl;
  ctl_t q_ctl;

  always_comb begin
    nx_ctl.cke   = nx_cke;
    nx_ctl.cs_n  = nx_cs_n;
    nx_ctl.ras_n = nx_ras_n;
    nx_ctl.cas_n = nx_cas_n;
    nx_ctl.we_n  = nx_we_n;
  end

  ddr_cmd_reg #(.BA_W(BA_W), .ADDR_W(ADDR_W)) i_cmd (
    .clk     (clk),
    .rst     (rst),
    .nx_ctl  (nx_ctl),
    .nx_ba   (nx_ba),
    .nx_addr (nx_addr),
    .q_ctl   (q_ctl),
    .q_ba    (mem_ba),
    .q_addr  (mem_addr)
  );

  assign mem_cke   = q_ctl.cke;
  assign mem_cs_n  = q_ctl.cs_n;
  assign mem_ras_n = q_ctl.ras_n;
  assign mem_cas_n = q_ctl.cas_n;
  assign mem_we_n  = q_ctl.we_n;

  ddr_ck_gen i_ck (
    .clk_p90  (clk_p90),
    .rst_p90  (rst_p90),
    .clk_p270 (clk_p270),
    .rst_p270 (rst_p270),
    .ck_p     (mem_ck_p),
    .ck_n     (mem_ck_n)
  );

  ddr_wr_path #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) i_wr (
    .clk        (clk),
    .rst        (rst),
    .clk_p90    (clk_p90),
    .rst_p90    (rst_p90),
    .nx_wr_en   (nx_wr_en),
    .nx_wr_data (nx_wr_data),
    .dq_o       (mem_dq_o),
    .dq_oe      (mem_dq_oe),
    .dqs_o      (mem_dqs_o),
    .dqs_oe     (mem_dqs_oe)
  );

  ddr_rd_path #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) i_rd (
    .clk       (clk),
    .rst       (rst),
    .rclk_p90  (rclk_p90),
    .rst_r90   (rst_r90),
    .rclk_p270 (rclk_p270),
    .rst_r270  (rst_r270),
    .nx_rd_en  (nx_rd_en),
    .dq_i      (mem_dq_i),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // R5
  dqs_lanes_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_dqs_o == '0) || (mem_dqs_o == '1));

endmodule

// File: tb/test_ddr_phy.sv
`timescale 1ns/1ps
module test_ddr_phy;
  localparam int CL = 2, BL = 4, HALF = BL / 2, DW = 32, QW = 16, NCYC = 1024;

  logic clk = 0, ck90 = 0, ck270 = 0, fbk = 0, rck90 = 0, rck270 = 0;
  logic rst = 1;
  logic nx_cke = 0, nx_cs_n = 1, nx_ras_n = 1, nx_cas_n = 1, nx_we_n = 1;
  logic [1:0]  nx_ba = 0;
  logic [12:0] nx_addr = 0;
  logic nx_wr_en = 0, nx_rd_en = 0;
  logic [DW-1:0] nx_wr_data = 0;
  logic [DW-1:0] rd_data;
  logic rd_valid, mem_ck_p, mem_ck_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [1:0]  mem_ba;
  logic [12:0] mem_addr;
  logic [QW-1:0] mem_dq_o;
  logic [QW-1:0] mem_dq_i = 16'h5A5A;
  logic mem_dq_oe, mem_dqs_oe;
  logic [1:0] mem_dqs_o;

  ddr_phy i_ddr_phy (
    .clk(clk), .rst(rst), .clk_p90(ck90), .rst_p90(rst), .clk_p270(ck270), .rst_p270(rst),
    .rclk_p90(rck90), .rst_r90(rst), .rclk_p270(rck270), .rst_r270(rst),
    .nx_cke(nx_cke), .nx_cs_n(nx_cs_n), .nx_ras_n(nx_ras_n), .nx_cas_n(nx_cas_n),
    .nx_we_n(nx_we_n), .nx_ba(nx_ba), .nx_addr(nx_addr), .nx_wr_en(nx_wr_en),
    .nx_wr_data(nx_wr_data), .nx_rd_en(nx_rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_ck_p(mem_ck_p), .mem_ck_n(mem_ck_n), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .mem_dqs_o(mem_dqs_o), .mem_dqs_oe(mem_dqs_oe)
  );

  // 200 MHz base clock and its quarter phases; feedback clock lags by 0.5 ns.
  initial begin #5.0;  forever begin clk = 1;    #2.5; clk = 0;    #2.5; end end
  initial begin #6.25; forever begin ck90 = 1;   #2.5; ck90 = 0;   #2.5; end end
  initial begin #8.75; forever begin ck270 = 1;  #2.5; ck270 = 0;  #2.5; end end
  initial begin #6.75; forever begin fbk = 1;    #2.5; fbk = 0;    #2.5; end end
  initial begin #8.0;  forever begin rck90 = 1;  #2.5; rck90 = 0;  #2.5; end end
  initial begin #10.5; forever begin rck270 = 1; #2.5; rck270 = 0; #2.5; end end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic run = 0, done = 0;

  logic [19:0]   exp_cmd   [NCYC];
  logic          exp_cmd_v [NCYC];
  logic          exp_dqoe  [NCYC];
  logic [DW-1:0] exp_w     [NCYC];
  logic          exp_rv    [NCYC];
  logic [DW-1:0] exp_r     [NCYC];
  logic          mem_drv   [NCYC];
  logic [DW-1:0] mem_word  [NCYC];

  initial begin
    for (int i = 0; i < NCYC; i++) begin
      exp_cmd[i] = 0; exp_cmd_v[i] = 0; exp_dqoe[i] = 0; exp_w[i] = 0;
      exp_rv[i] = 0; exp_r[i] = 0; mem_drv[i] = 0; mem_word[i] = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, expv);
    end
  endtask

  // Drive one base cycle of inputs and record what must appear later.
  task automatic tick(input logic [19:0] cv, input logic we, input logic [DW-1:0] wd,
                      input logic re, input logic [DW-1:0] rw);
    int k;
    k = cyc + 1;
    {nx_cke, nx_cs_n, nx_ras_n, nx_cas_n, nx_we_n, nx_ba, nx_addr} = cv;
    nx_wr_en = we; nx_wr_data = wd; nx_rd_en = re;
    exp_cmd[k] = cv; exp_cmd_v[k] = 1;
    if (we) begin exp_dqoe[k+1] = 1; exp_w[k+1] = wd; end
    if (re) begin
      mem_drv[k+CL] = 1; mem_word[k+CL] = rw;
      exp_rv[k+CL+1] = 1; exp_r[k+CL+1] = rw;
    end
    @(negedge clk);
  endtask

  // Memory model: beats edge-aligned to the feedback clock, low half first.
  initial begin
    forever begin
      @(posedge fbk);
      if (mem_drv[cyc]) begin
        mem_dq_i = mem_word[cyc][15:0];
        #2.5;
        mem_dq_i = mem_word[cyc][31:16];
      end else begin
        mem_dq_i = 16'h5A5A ^ 16'(cyc);
      end
    end
  end

  // Per-cycle monitor, sampling away from every active edge.
  initial begin
    int c;
    wait (run);
    repeat (2) @(posedge clk);
    forever begin
      @(posedge clk);
      #0.5; c = cyc;
      #0.5;
      if (exp_cmd_v[c])
        chk("R1", {mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr}, exp_cmd[c]);
      chk("R4", mem_dq_oe, exp_dqoe[c]);
      if (exp_dqoe[c]) chk("R3 low half", mem_dq_o, exp_w[c][15:0]);
      #1.0;
      chk("R2 high", {mem_ck_p, mem_ck_n}, 2'b10);
      chk("R5 high-half oe", mem_dqs_oe, exp_dqoe[c]);
      if (exp_dqoe[c]) chk("R5 high level", mem_dqs_o, 2'b11);
      chk("R7 valid", rd_valid, exp_rv[c]);
      if (exp_rv[c]) chk("R6 word", rd_data, exp_r[c]);
      #1.5;
      if (exp_dqoe[c]) chk("R3 high half", mem_dq_o, exp_w[c][31:16]);
      #1.0;
      chk("R2 low", {mem_ck_p, mem_ck_n}, 2'b01);
      chk("R5 low-half oe", mem_dqs_oe, exp_dqoe[c] | exp_dqoe[c+1]);
      if (exp_dqoe[c] | exp_dqoe[c+1]) chk("R5 low level", mem_dqs_o, 2'b00);
    end
  end

  function automatic logic [19:0] cmdv(input int i);
    logic [5:0] b;
    b = 6'(i);
    return {1'b1, b[0], b[1], b[2], b[3], b[5:4], 13'(i * 97 + 5)};
  endfunction

  function automatic logic [DW-1:0] wpat(input int b, input int j);
    return {16'(b * 16'h1111 + j * 3), 16'(~(b * 16'h0707)) ^ 16'(j)};
  endfunction

  function automatic logic [DW-1:0] rpat(input int b, input int j);
    return {16'(16'hC000 + b * 16'h0123 + j), 16'(16'h0F0F ^ (b * 16'h1010 + j * 7))};
  endfunction

  localparam logic [19:0] CMD_WR = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 13'h0400};
  localparam logic [19:0] CMD_RD = {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 13'h0400};
  localparam logic [19:0] CMD_NOP = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0};

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1 reset", {mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr},
        {1'b0, 4'hF, 2'd0, 13'd0});
    chk("R2 reset", {mem_ck_p, mem_ck_n}, 2'b01);
    chk("R4 reset", mem_dq_oe, 1'b0);
    chk("R5 reset", mem_dqs_oe, 1'b0);
    chk("R7 reset", rd_valid, 1'b0);
    rst = 0;
    run = 1;
    // R1: full sweep of strobes and bank bits
    for (int i = 0; i < 64; i++) tick(cmdv(i), 0, '0, 0, '0);
    // R3 R4 R5 R8: write bursts with gaps 0, 1, 2
    for (int b = 0; b < 6; b++) begin
      for (int j = 0; j < HALF; j++) tick(j == 0 ? CMD_WR : CMD_NOP, 1, wpat(b, j), 0, '0);
      for (int g = 0; g < b % 3; g++) tick(cmdv(b + g), 0, '0, 0, '0);
    end
    repeat (3) tick(CMD_NOP, 0, '0, 0, '0);
    // R6 R7 R8: read bursts with gaps 0, 1, 2
    for (int b = 0; b < 6; b++) begin
      for (int j = 0; j < HALF; j++) tick(j == 0 ? CMD_RD : CMD_NOP, 0, '0, 1, rpat(b, j));
      for (int g = 0; g < b % 3; g++) tick(CMD_NOP, 0, '0, 0, '0);
    end
    // Mixed: write then read back to back, read then write
    for (int b = 6; b < 9; b++) begin
      for (int j = 0; j < HALF; j++) tick(j == 0 ? CMD_WR : CMD_NOP, 1, wpat(b, j), 0, '0);
      for (int j = 0; j < HALF; j++) tick(j == 0 ? CMD_RD : CMD_NOP, 0, '0, 1, rpat(b, j));
      tick(CMD_NOP, 0, '0, 0, '0);
    end
    repeat (12) tick(CMD_NOP, 0, '0, 0, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule